// File: doc/BRIEF.md
# Sprite Attribute Block-Copy Engine

This engine fills the sprite attribute memory from an ordinary memory page with no CPU work per byte. The CPU writes a page number to one trigger address on its write port. The engine then reads a fixed-length run of bytes that starts at the bottom of that page. It writes each byte into the attribute memory, starting at a fixed destination base. Each destination address is one higher than the last.

Reads go out on a source read port toward the system bus. That port has a read latency of one cycle. Each byte read in one cycle is written in the next. The read stage and the write stage overlap, so the copy moves one byte per cycle after a single fill cycle. A busy output tells the surrounding logic that the bus is in use and the CPU should be stalled. A new trigger write that arrives during a copy abandons the copy in progress and starts again from the new page.

Top module: `sprite_dma`

## Requirements
- R1: After reset, and at once whenever reset is asserted (including during a copy), busy, srcRdEn and sprWrEn are all 0.
- R2: Only a CPU write with address 0xFF46 starts a copy. A CPU write to any other address leaves busy, srcRdEn and sprWrEn at 0 when the engine is idle.
- R3: In the first cycle after the trigger edge, srcRdEn is 1 and srcRdAddr equals the written byte shifted left by 8, so its low byte is 0x00. Each later read address is one higher than the previous one.
- R4: One copy issues exactly 160 reads, in the 160 consecutive cycles that follow the trigger edge, and exactly 160 writes.
- R5: The write of byte i has address 0xFE00+i. It occurs in the cycle after the read of byte i, and its data is the srcRdData returned for that read. The 160 destination bytes end up equal to source bytes page*256+0 through page*256+159.
- R6: busy rises in the cycle after the trigger edge and stays high for exactly 161 cycles: one fill cycle plus 160 transfer cycles. It falls in the cycle after the final write.
- R7: A trigger write during a copy restarts it from the new page. A write already presented in the trigger cycle still completes. The read that was in flight at the trigger edge is never written. The restarted copy follows R3 to R6, counted from the new trigger edge.
- R8: srcRdData is taken as valid exactly one cycle after the cycle in which srcRdEn and srcRdAddr were presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuWrEn | input | 1 | CPU write strobe |
| cpuWrAddr | input | 16 | CPU write address |
| cpuWrData | input | 8 | CPU write data (the page number on a trigger) |
| srcRdEn | output | 1 | Source read request |
| srcRdAddr | output | 16 | Source read address |
| srcRdData | input | 8 | Source read data, one cycle after the request |
| sprWrEn | output | 1 | Attribute memory write strobe |
| sprWrAddr | output | 16 | Attribute memory write address |
| sprWrData | output | 8 | Attribute memory write data |
| busy | output | 1 | High while a copy occupies the bus |

## Verification
A new trigger and a pending write can land in the same cycle. At that point a write of the old page is on the attribute port while the read stage is being reloaded with the new page. The bench provokes this by retriggering at chosen offsets into a running copy: the first read cycle, a random middle point, and the final write-only cycle. It judges the result in three ways. The write in the trigger cycle must still be present. No write may follow in the next cycle. The whole destination must end up holding the new page, with exactly 160 writes and 161 busy cycles counted from the retrigger.

// File: rtl/sprite_dma_pkg.sv
package sprite_dma_pkg;

  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic start;   // load page, clear both offsets
    logic rdStep;  // a read is issued this cycle
    logic wrStep;  // a write is issued this cycle
  } dmaStrobes_t;

endpackage

// File: rtl/sprite_dma_ctrl.sv
module sprite_dma_ctrl
  import sprite_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'hFF46
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWrEn,
  input  logic [ADDR_W-1:0] cpuWrAddr,
  input  logic              rdLast,
  output dmaStrobes_t       strobes,
  output logic              rdActive,
  output logic              wrActive,
  output logic              busy
);

  logic trig;

  assign trig = cpuWrEn && (cpuWrAddr == TRIG_ADDR);

  // Read stage runs from the trigger until the last offset is issued
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdActive <= 1'b0;
    end else if (trig) begin
      rdActive <= 1'b1;
    end else if (rdActive && rdLast) begin
      rdActive <= 1'b0;
    end
  end

  // Write stage trails the read stage by one cycle; a restart drops it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrActive <= 1'b0;
    end else if (trig) begin
      wrActive <= 1'b0;
    end else begin
      wrActive <= rdActive;
    end
  end

  always_comb begin
    strobes.start  = trig;
    strobes.rdStep = rdActive;
    strobes.wrStep = wrActive;
  end

  assign busy = rdActive || wrActive;

  // R2
  trig_starts_chk: assert property (@(posedge clk) disable iff (!rstN)
    trig |=> (rdActive && !wrActive));

  // R4
  read_stops_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdActive && rdLast && !trig) |=> !rdActive);

  // R6
  busy_tail_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(wrActive) && !$past(rdActive)));

  // R7
  restart_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trig && rdActive) |=> !wrActive);

endmodule

// File: rtl/sprite_dma_path.sv
module sprite_dma_path
  import sprite_dma_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int XFER_LEN   = 160,
  parameter int PAGE_SHIFT = 8,
  parameter logic [ADDR_W-1:0] DEST_BASE = 16'hFE00
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobes_t       strobes,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic [DATA_W-1:0] srcRdData,
  output logic              rdLast,
  output logic [ADDR_W-1:0] srcRdAddr,
  output logic [ADDR_W-1:0] sprWrAddr,
  output logic [DATA_W-1:0] sprWrData
);

  localparam int OFF_W = (XFER_LEN > 1) ? $clog2(XFER_LEN) : 1;
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(XFER_LEN - 1);
  localparam logic [ADDR_W-1:0] DEST_END = ADDR_W'(DEST_BASE + XFER_LEN - 1);

  generate
    if (XFER_LEN > (1 << PAGE_SHIFT)) begin : g_len_bad
      $error("copy length exceeds one source page");
    end
  endgenerate

  logic [DATA_W-1:0] pageQ;
  logic [OFF_W-1:0]  rdOff;
  logic [OFF_W-1:0]  wrOff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageQ <= '0;
      rdOff <= '0;
      wrOff <= '0;
    end else if (strobes.start) begin
      pageQ <= cpuWrData;
      rdOff <= '0;
      wrOff <= '0;
    end else begin
      if (strobes.rdStep) rdOff <= (rdOff == LAST_OFF) ? '0 : rdOff + 1'b1;
      if (strobes.wrStep) wrOff <= wrOff + 1'b1;
    end
  end

  assign rdLast    = (rdOff == LAST_OFF);
  assign srcRdAddr = (ADDR_W'(pageQ) << PAGE_SHIFT) | ADDR_W'(rdOff);
  assign sprWrAddr = DEST_BASE + ADDR_W'(wrOff);
  assign sprWrData = srcRdData;

  // R3
  rd_addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdStep && !rdLast && !strobes.start) |=> (srcRdAddr == $past(srcRdAddr) + 1'b1));

  // R3
  rd_addr_base_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.start |=> (srcRdAddr == (ADDR_W'($past(cpuWrData)) << PAGE_SHIFT)));

  // R5
  wr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrStep |-> (sprWrAddr >= DEST_BASE && sprWrAddr <= DEST_END));

  // R5
  wr_follows_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdStep && !strobes.start) |=>
      ((sprWrAddr - DEST_BASE) == ($past(srcRdAddr) - (ADDR_W'($past(pageQ)) << PAGE_SHIFT))));

endmodule

// File: rtl/sprite_dma.sv
module sprite_dma
  import sprite_dma_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int XFER_LEN   = 160,
  parameter int PAGE_SHIFT = 8,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'hFF46,
  parameter logic [ADDR_W-1:0] DEST_BASE = 16'hFE00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWrEn,
  input  logic [ADDR_W-1:0] cpuWrAddr,
  input  logic [DATA_W-1:0] cpuWrData,
  output logic              srcRdEn,
  output logic [ADDR_W-1:0] srcRdAddr,
  input  logic [DATA_W-1:0] srcRdData,
  output logic              sprWrEn,
  output logic [ADDR_W-1:0] sprWrAddr,
  output logic [DATA_W-1:0] sprWrData,
  output logic              busy
);

  dmaStrobes_t strobes;
  logic rdLast;
  logic rdActive;
  logic wrActive;

  sprite_dma_ctrl #(
    .ADDR_W   (ADDR_W),
    .TRIG_ADDR(TRIG_ADDR)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cpuWrEn  (cpuWrEn),
    .cpuWrAddr(cpuWrAddr),
    .rdLast   (rdLast),
    .strobes  (strobes),
    .rdActive (rdActive),
    .wrActive (wrActive),
    .busy     (busy)
  );

  sprite_dma_path #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .XFER_LEN  (XFER_LEN),
    .PAGE_SHIFT(PAGE_SHIFT),
    .DEST_BASE (DEST_BASE)
  ) i_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .cpuWrData(cpuWrData),
    .srcRdData(srcRdData),
    .rdLast   (rdLast),
    .srcRdAddr(srcRdAddr),
    .sprWrAddr(sprWrAddr),
    .sprWrData(sprWrData)
  );

  assign srcRdEn = rdActive;
  assign sprWrEn = wrActive;

  // R8
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcRdEn && !(cpuWrEn && cpuWrAddr == TRIG_ADDR)) |=> sprWrEn);

  // R1
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!srcRdEn && !sprWrEn));

endmodule

// File: tb/test_sprite_dma.sv
`timescale 1ns/1ps
module test_sprite_dma;

  localparam int LEN = 160;
  localparam int BUSY_EXP = LEN + 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuWrEn = 1'b0;
  logic [15:0] cpuWrAddr = '0;
  logic [7:0]  cpuWrData = '0;
  logic        srcRdEn;
  logic [15:0] srcRdAddr;
  logic [7:0]  srcRdData = '0;
  logic        sprWrEn;
  logic [15:0] sprWrAddr;
  logic [7:0]  sprWrData;
  logic        busy;

  int nChecks = 0;
  int nFails  = 0;
  int wrCount = 0;
  int badAddr = 0;
  logic [7:0] sprMem [LEN];

  always #5 clk = ~clk;

  sprite_dma i_sprite_dma (
    .clk(clk), .rstN(rstN),
    .cpuWrEn(cpuWrEn), .cpuWrAddr(cpuWrAddr), .cpuWrData(cpuWrData),
    .srcRdEn(srcRdEn), .srcRdAddr(srcRdAddr), .srcRdData(srcRdData),
    .sprWrEn(sprWrEn), .sprWrAddr(sprWrAddr), .sprWrData(sprWrData),
    .busy(busy)
  );

  function automatic logic [7:0] srcByte(input logic [15:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
  endfunction

  // Source memory: one-cycle read latency (R8)
  always @(posedge clk) if (srcRdEn) srcRdData <= srcByte(srcRdAddr);

  // Attribute memory model
  always @(posedge clk) begin
    if (rstN && sprWrEn) begin
      if (sprWrAddr >= 16'hFE00 && sprWrAddr < 16'hFE00 + LEN) begin
        sprMem[sprWrAddr - 16'hFE00] = sprWrData;
        wrCount = wrCount + 1;
      end else begin
        badAddr = badAddr + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cpuWrite(input logic [15:0] a, input logic [7:0] d);
    cpuWrEn = 1'b1; cpuWrAddr = a; cpuWrData = d;
    @(posedge clk);
    @(negedge clk);
    cpuWrEn = 1'b0;
  endtask

  // Called at a negedge right after the trigger edge; leaves at first idle negedge
  task automatic followCopy(input logic [7:0] page, input int wrBase);
    int busyCycles = 0;
    int mism = 0;
    int firstBad = -1;
    check(srcRdEn && srcRdAddr == {page, 8'h00}, "R3", srcRdAddr, {page, 8'h00});
    check(!sprWrEn, "R7", sprWrEn, 0);
    while (busy && busyCycles < 1000) begin
      busyCycles++;
      @(negedge clk);
    end
    check(busyCycles == BUSY_EXP, "R6", busyCycles, BUSY_EXP);
    check(wrCount - wrBase == LEN, "R4", wrCount - wrBase, LEN);
    for (int i = 0; i < LEN; i++) begin
      if (sprMem[i] !== srcByte({page, 8'h00} + 16'(i))) begin
        mism++;
        if (firstBad < 0) firstBad = i;
      end
    end
    check(mism == 0, "R5", (firstBad < 0) ? 0 : sprMem[firstBad],
          (firstBad < 0) ? 0 : srcByte({page, 8'h00} + 16'(firstBad)));
    check(badAddr == 0, "R5", badAddr, 0);
  endtask

  task automatic retrigger(input logic [7:0] pageA, input logic [7:0] pageB, input int at);
    int base;
    cpuWrite(16'hFF46, pageA);
    for (int j = 1; j < at; j++) @(negedge clk);
    // now in cycle 'at' after the first trigger edge
    if (at >= 2) check(sprWrEn == 1'b1, "R7", sprWrEn, 1);
    cpuWrite(16'hFF46, pageB);
    base = wrCount;
    followCopy(pageB, base);
  endtask

  initial begin
    void'($urandom(32'd2024));
    // R1: reset state
    @(negedge clk);
    check(!busy && !srcRdEn && !sprWrEn, "R1", {busy, srcRdEn, sprWrEn}, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !srcRdEn && !sprWrEn, "R1", {busy, srcRdEn, sprWrEn}, 0);

    // R2: non-trigger writes ignored
    foreach (sprMem[i]) sprMem[i] = 8'h00;
    begin
      logic [15:0] others [4] = '{16'hFF45, 16'hFF47, 16'hFE46, 16'h7F46};
      for (int k = 0; k < 4; k++) begin
        cpuWrite(others[k], 8'h3C);
        check(!busy && !srcRdEn && !sprWrEn, "R2", {busy, srcRdEn, sprWrEn}, 0);
      end
      for (int k = 0; k < 6; k++) begin
        logic [15:0] a = 16'($urandom());
        if (a == 16'hFF46) a = 16'hFF40;
        cpuWrite(a, 8'($urandom()));
        check(!busy && !srcRdEn && !sprWrEn, "R2", {busy, srcRdEn, sprWrEn}, 0);
      end
      check(wrCount == 0, "R2", wrCount, 0);
    end

    // Directed pages: low, high, then random ones (R3..R6, R8)
    begin
      int base;
      base = wrCount; cpuWrite(16'hFF46, 8'h00); followCopy(8'h00, base);
      base = wrCount; cpuWrite(16'hFF46, 8'hFF); followCopy(8'hFF, base);
      for (int k = 0; k < 5; k++) begin
        logic [7:0] p = 8'($urandom());
        base = wrCount;
        cpuWrite(16'hFF46, p);
        followCopy(p, base);
        repeat ($urandom_range(0, 3)) @(negedge clk);
      end
    end

    // R7: retrigger at the first read, a random point, the last write cycle
    retrigger(8'h12, 8'h34, 1);
    retrigger(8'h56, 8'h78, int'($urandom_range(2, 159)));
    retrigger(8'h9A, 8'hBC, LEN + 1);

    // R1: reset in the middle of a copy
    cpuWrite(16'hFF46, 8'h44);
    repeat (20) @(negedge clk);
    rstN = 1'b0;
    #1;
    check(!busy && !srcRdEn && !sprWrEn, "R1", {busy, srcRdEn, sprWrEn}, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !srcRdEn && !sprWrEn, "R1", {busy, srcRdEn, sprWrEn}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule